// File: doc/BRIEF.md
# Copy-Engine Channel Register Bank

This block is the software-visible register bank of a multi-channel copy engine. A simple request bus carries one access per cycle with an address, a write flag, an access size in bytes and a right-aligned little-endian data word. The block decodes the address into a small global region or into one of the per-channel windows, and updates or returns the addressed register.

Each channel keeps six registers: control, status, chain pointer, command, completion pointer and error. A command write is turned into a one-cycle start, append or reset pulse for that channel's sequencer. The sequencer reports back through three per-channel inputs. The first is a busy level. The second is a completion-status word with a load strobe. The third is a mask of error bits to set.

Reads return data one cycle after the request. Every rejected access raises a one-cycle error flag and has no effect on any register.

Top module: `dmareg_bank`

## Requirements
- R1: Addresses below 0x80 form the global region. Channel k (0 ≤ k < N_CHAN) owns the 0x80-byte window starting at 0x80·(k+1). The only global register is a 1-byte read-only channel-count register at offset 0x00, which reads as N_CHAN. A 1-byte write to it is accepted without error and changes nothing.
- R2: An access is rejected in any of these cases:
    - its channel index is N_CHAN or higher;
    - its offset is not a register;
    - its size is not allowed for that register.
  A rejected access sets acc_err for the one cycle after the request, returns rd_data = 0 on a read, and changes no register. Channel offsets and their allowed sizes are: control 0x00 (2 bytes), status 0x08 (8), chain low 0x10 (8 or 4), chain high 0x14 (4), command 0x18 (1), completion low 0x20 (8 or 4), completion high 0x24 (4), error 0x28 (4).
- R3: Any access size other than 1, 2, 4 or 8 bytes is rejected as in R2.
- R4: A read request is answered in the next cycle with rd_valid = 1 and the data. A write produces no rd_valid.
- R5: A status read returns the stored status word with bit 0 forced to 1 whenever the channel's busy input is low in the request cycle. A write to the status register is accepted and ignored.
- R6: For the chain and completion pointers, each of 64 bits:
    - an 8-byte write at the low offset loads all 64 bits;
    - a 4-byte write at the low offset replaces bits 31:0 only;
    - a 4-byte write at the high offset replaces bits 63:32 only.
  A 4-byte read at the low offset returns bits 31:0. A 4-byte read at the high offset returns bits 63:32. An 8-byte read at the low offset returns all 64 bits.
- R7: A write to the error register clears each bit written as 1 and keeps the others. The sequencer's error-set mask ORs bits in every cycle. When a set and a clear hit the same bit in the same cycle, the set wins.
- R8: Control bit 0 is the interrupt-disable bit. On a control write, bits 15:1 take the written value. Bit 0 becomes 0 if the written bit 0 is 1, and otherwise keeps its old value.
- R9: The command byte is stored and read back as written. Its bits are: bit0 start, bit1 append, bit4 reset, and bits 2, 3 and 5 unsupported.
    - Decode priority is start, then append, then reset.
    - The chosen pulse appears for one cycle in the cycle after the write.
    - Start sets status bits 2:0 to 0.
    - Reset sets status bits 2:0 to 3.
- R10: A command write whose byte has any unsupported bit set, and none of start, append or reset, is rejected as in R2. No pulse is sent and the command register keeps its old value.
- R11: A completion strobe loads the channel's whole status word from the sequencer. In the same cycle, a start or reset command then overrides bits 2:0.
- R12: After reset:
    - control holds 0x0001;
    - status holds 3;
    - both pointers, the command register and the error register hold 0;
    - no pulse, no rd_valid and no acc_err are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address of the access |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 64 | Right-aligned write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 64 | Read data, right-aligned |
| acc_err | output | 1 | One-cycle flag for a rejected access |
| cmd_start | output | N_CHAN | Per-channel start pulse |
| cmd_append | output | N_CHAN | Per-channel append pulse |
| cmd_reset | output | N_CHAN | Per-channel reset pulse |
| seq_busy | input | N_CHAN | Per-channel busy level from the sequencer |
| seq_cmpl_upd | input | N_CHAN | Per-channel completion-status load strobe |
| seq_cmpl_word | input | 64·N_CHAN | Completion status words, channel i in bits 64i+63:64i |
| seq_err_set | input | 32·N_CHAN | Error bits to set, channel i in bits 32i+31:32i |

## Verification
Some rules are checked by the assertions in every cycle:
- a read is answered exactly one cycle later;
- acc_err is raised only after a request, and a rejected read returns zero;
- at most one command pulse fires per channel;
- a start or reset pulse coincides with the matching status field;
- the interrupt-disable bit never rises;
- the error and status registers stay stable when nothing is allowed to change them.

Other behaviour needs the bench's scenarios to show it:
- half-pointer merging;
- the live idle bit under different busy levels;
- write-one-to-clear racing a set;
- command priority and rejection;
- channel-window decoding at the edge of the channel count;
- the absence of side effects from rejected writes.

These can only be seen by reading values back after directed and random access sequences.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

    // Register selector produced by the address decoder
    typedef enum logic [3:0] {
        REG_NONE,
        REG_GCOUNT,
        REG_CTRL,
        REG_STATUS,
        REG_CHAIN_LO,
        REG_CHAIN_HI,
        REG_CMD,
        REG_CMPL_LO,
        REG_CMPL_HI,
        REG_ERR
    } reg_sel_e;

    // Per-channel register state
    typedef struct packed {
        logic [15:0] ctrl;
        logic [63:0] status;
        logic [63:0] chain;
        logic [7:0]  cmd;
        logic [63:0] cmpl;
        logic [31:0] err;
    } chan_regs_t;

    localparam int WIN_BITS = 7;          // 0x80-byte windows
    localparam int MAX_CHAN = 64;

    // Channel window offsets
    localparam logic [6:0] OFF_CTRL     = 7'h00;
    localparam logic [6:0] OFF_STATUS   = 7'h08;
    localparam logic [6:0] OFF_CHAIN_LO = 7'h10;
    localparam logic [6:0] OFF_CHAIN_HI = 7'h14;
    localparam logic [6:0] OFF_CMD      = 7'h18;
    localparam logic [6:0] OFF_CMPL_LO  = 7'h20;
    localparam logic [6:0] OFF_CMPL_HI  = 7'h24;
    localparam logic [6:0] OFF_ERR      = 7'h28;
    localparam logic [6:0] OFF_GCOUNT   = 7'h00;

    // Command byte bits
    localparam int CMD_START   = 0;
    localparam int CMD_APPEND  = 1;
    localparam int CMD_SUSPEND = 2;
    localparam int CMD_ABORT   = 3;
    localparam int CMD_RESET   = 4;
    localparam int CMD_RESUME  = 5;

    // Transfer-status field in status bits 2:0
    localparam int         XFER_W    = 3;
    localparam logic [2:0] XFER_RUN  = 3'd0;
    localparam logic [2:0] XFER_IDLE = 3'd3;

    localparam logic [15:0] CTRL_RST_DEFAULT = 16'h0001;

    function automatic logic size_legal(input logic [3:0] sz);
        return (sz == 4'd1) || (sz == 4'd2) || (sz == 4'd4) || (sz == 4'd8);
    endfunction

    // Map a channel offset and access size to a register, NONE on mismatch
    function automatic reg_sel_e chan_lookup(input logic [6:0] off, input logic [3:0] sz);
        reg_sel_e r;
        r = REG_NONE;
        case (off)
            OFF_CTRL:     if (sz == 4'd2) r = REG_CTRL;
            OFF_STATUS:   if (sz == 4'd8) r = REG_STATUS;
            OFF_CHAIN_LO: if (sz == 4'd8 || sz == 4'd4) r = REG_CHAIN_LO;
            OFF_CHAIN_HI: if (sz == 4'd4) r = REG_CHAIN_HI;
            OFF_CMD:      if (sz == 4'd1) r = REG_CMD;
            OFF_CMPL_LO:  if (sz == 4'd8 || sz == 4'd4) r = REG_CMPL_LO;
            OFF_CMPL_HI:  if (sz == 4'd4) r = REG_CMPL_HI;
            OFF_ERR:      if (sz == 4'd4) r = REG_ERR;
            default:      r = REG_NONE;
        endcase
        return r;
    endfunction

    function automatic logic cmd_supported(input logic [7:0] c);
        return c[CMD_START] | c[CMD_APPEND] | c[CMD_RESET];
    endfunction

    function automatic logic cmd_rejected(input logic [7:0] c);
        return (c[CMD_SUSPEND] | c[CMD_ABORT] | c[CMD_RESUME]) & ~cmd_supported(c);
    endfunction

    // Merge a write into a 64-bit pointer
    function automatic logic [63:0] ptr_merge(input logic [63:0] old, input logic [63:0] wd,
                                              input logic [3:0] sz, input logic upper);
        logic [63:0] r;
        if (upper)
            r = {wd[31:0], old[31:0]};
        else if (sz == 4'd8)
            r = wd;
        else
            r = {old[63:32], wd[31:0]};
        return r;
    endfunction

    // Read view of a 64-bit pointer
    function automatic logic [63:0] ptr_view(input logic [63:0] p, input logic [3:0] sz,
                                             input logic upper);
        logic [63:0] r;
        if (upper)
            r = {32'd0, p[63:32]};
        else if (sz == 4'd8)
            r = p;
        else
            r = {32'd0, p[31:0]};
        return r;
    endfunction

endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
    import dmareg_pkg::*;
#(
    parameter int N_CHAN = 4,
    parameter int AW     = 16,
    localparam int WW    = AW - WIN_BITS,
    localparam int CH_W  = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
    input  logic [AW-1:0]   addr,
    input  logic [3:0]      size,
    input  logic            we,
    input  logic [7:0]      wbyte,
    output logic            is_global,
    output logic [CH_W-1:0] chan,
    output reg_sel_e        sel,
    output logic            err
);

    logic [WW-1:0]       win;
    logic [WIN_BITS-1:0] off;
    logic                in_range;

    assign win       = addr[AW-1:WIN_BITS];
    assign off       = addr[WIN_BITS-1:0];
    assign is_global = (win == '0);
    assign in_range  = !is_global && (win <= WW'(N_CHAN));
    assign chan      = CH_W'(win - WW'(1));

    always_comb begin
        if (is_global)
            sel = (off == OFF_GCOUNT && size == 4'd1) ? REG_GCOUNT : REG_NONE;
        else
            sel = chan_lookup(off, size);
    end

    always_comb begin
        err = 1'b0;
        if (!size_legal(size))
            err = 1'b1;
        else if (!is_global && !in_range)
            err = 1'b1;
        else if (sel == REG_NONE)
            err = 1'b1;
        else if (we && sel == REG_CMD && cmd_rejected(wbyte))
            err = 1'b1;
    end

endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
    import dmareg_pkg::*;
#(
    parameter logic [15:0] CTRL_RST = CTRL_RST_DEFAULT
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  reg_sel_e    sel,
    input  logic [3:0]  size,
    input  logic [63:0] wdata,
    input  logic        busy,
    input  logic        cmpl_upd,
    input  logic [63:0] cmpl_word,
    input  logic [31:0] err_set,
    output logic [63:0] rd_word,
    output logic        cmd_start,
    output logic        cmd_append,
    output logic        cmd_reset
);

    chan_regs_t q, nx;
    logic       start_n, append_n, reset_n;

    always_comb begin
        nx       = q;
        start_n  = 1'b0;
        append_n = 1'b0;
        reset_n  = 1'b0;
        if (cmpl_upd)
            nx.status = cmpl_word;
        if (wr_en) begin
            case (sel)
                REG_CTRL:     nx.ctrl  = {wdata[15:1], wdata[0] ? 1'b0 : q.ctrl[0]};
                REG_CHAIN_LO: nx.chain = ptr_merge(q.chain, wdata, size, 1'b0);
                REG_CHAIN_HI: nx.chain = ptr_merge(q.chain, wdata, size, 1'b1);
                REG_CMPL_LO:  nx.cmpl  = ptr_merge(q.cmpl, wdata, size, 1'b0);
                REG_CMPL_HI:  nx.cmpl  = ptr_merge(q.cmpl, wdata, size, 1'b1);
                REG_ERR:      nx.err   = q.err & ~wdata[31:0];
                REG_CMD: begin
                    nx.cmd = wdata[7:0];
                    if (wdata[CMD_START]) begin
                        start_n = 1'b1;
                        nx.status[XFER_W-1:0] = XFER_RUN;
                    end else if (wdata[CMD_APPEND]) begin
                        append_n = 1'b1;
                    end else if (wdata[CMD_RESET]) begin
                        reset_n = 1'b1;
                        nx.status[XFER_W-1:0] = XFER_IDLE;
                    end
                end
                default: ;
            endcase
        end
        nx.err = nx.err | err_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.ctrl     <= CTRL_RST;
            q.status   <= {61'd0, XFER_IDLE};
            q.chain    <= '0;
            q.cmd      <= '0;
            q.cmpl     <= '0;
            q.err      <= '0;
            cmd_start  <= 1'b0;
            cmd_append <= 1'b0;
            cmd_reset  <= 1'b0;
        end else begin
            q          <= nx;
            cmd_start  <= start_n;
            cmd_append <= append_n;
            cmd_reset  <= reset_n;
        end
    end

    always_comb begin
        case (sel)
            REG_CTRL:     rd_word = {48'd0, q.ctrl};
            REG_STATUS:   rd_word = q.status | {63'd0, ~busy};
            REG_CHAIN_LO: rd_word = ptr_view(q.chain, size, 1'b0);
            REG_CHAIN_HI: rd_word = ptr_view(q.chain, size, 1'b1);
            REG_CMD:      rd_word = {56'd0, q.cmd};
            REG_CMPL_LO:  rd_word = ptr_view(q.cmpl, size, 1'b0);
            REG_CMPL_HI:  rd_word = ptr_view(q.cmpl, size, 1'b1);
            REG_ERR:      rd_word = {32'd0, q.err};
            default:      rd_word = '0;
        endcase
    end

    // R9: one command pulse at most per channel
    assert_cmd_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_start, cmd_append, cmd_reset}));

    // R9: start pulse coincides with a running transfer-status field
    assert_start_field_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> q.status[XFER_W-1:0] == XFER_RUN);

    // R9: reset pulse coincides with an idle transfer-status field
    assert_reset_field_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_reset |-> q.status[XFER_W-1:0] == XFER_IDLE);

    // R8: writes can only clear the interrupt-disable bit
    assert_intdis_no_rise_R8: assert property (@(posedge clk) disable iff (rst)
        !$rose(q.ctrl[0]));

    // R7: error bits stay put without a write or a set
    assert_err_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && sel == REG_ERR) && err_set == '0) |=> $stable(q.err));

    // R5: status changes only through completion load or command
    assert_status_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!cmpl_upd && !(wr_en && sel == REG_CMD)) |=> $stable(q.status));

endmodule

// File: rtl/dmareg_bank.sv
module dmareg_bank
    import dmareg_pkg::*;
#(
    parameter int N_CHAN = 4,
    parameter int AW     = 16,
    parameter logic [15:0] CTRL_RST = CTRL_RST_DEFAULT,
    localparam int CH_W  = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [AW-1:0]        bus_addr,
    input  logic [3:0]           bus_size,
    input  logic [63:0]          bus_wdata,
    output logic                 rd_valid,
    output logic [63:0]          rd_data,
    output logic                 acc_err,
    output logic [N_CHAN-1:0]    cmd_start,
    output logic [N_CHAN-1:0]    cmd_append,
    output logic [N_CHAN-1:0]    cmd_reset,
    input  logic [N_CHAN-1:0]    seq_busy,
    input  logic [N_CHAN-1:0]    seq_cmpl_upd,
    input  logic [N_CHAN*64-1:0] seq_cmpl_word,
    input  logic [N_CHAN*32-1:0] seq_err_set
);

    if (N_CHAN < 1 || N_CHAN > MAX_CHAN) begin : g_bad_cfg
        $error("dmareg_bank: N_CHAN must be between 1 and 64");
    end

    logic            dec_global;
    logic [CH_W-1:0] dec_chan;
    reg_sel_e        dec_sel;
    logic            dec_err;
    logic [63:0]     ch_rd [N_CHAN];
    logic [63:0]     rd_next;

    dmareg_decode #(.N_CHAN(N_CHAN), .AW(AW)) u_decode (
        .addr      (bus_addr),
        .size      (bus_size),
        .we        (bus_we),
        .wbyte     (bus_wdata[7:0]),
        .is_global (dec_global),
        .chan      (dec_chan),
        .sel       (dec_sel),
        .err       (dec_err)
    );

    for (genvar i = 0; i < N_CHAN; i++) begin : g_chan
        logic wr_hit;
        assign wr_hit = bus_req && bus_we && !dec_err && !dec_global
                        && (dec_chan == CH_W'(i));
        dmareg_chan #(.CTRL_RST(CTRL_RST)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (wr_hit),
            .sel        (dec_sel),
            .size       (bus_size),
            .wdata      (bus_wdata),
            .busy       (seq_busy[i]),
            .cmpl_upd   (seq_cmpl_upd[i]),
            .cmpl_word  (seq_cmpl_word[i*64 +: 64]),
            .err_set    (seq_err_set[i*32 +: 32]),
            .rd_word    (ch_rd[i]),
            .cmd_start  (cmd_start[i]),
            .cmd_append (cmd_append[i]),
            .cmd_reset  (cmd_reset[i])
        );
    end

    always_comb begin
        if (dec_err)
            rd_next = '0;
        else if (dec_global)
            rd_next = 64'(N_CHAN);
        else
            rd_next = ch_rd[dec_chan];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            acc_err  <= 1'b0;
        end else begin
            rd_valid <= bus_req && !bus_we;
            acc_err  <= bus_req && dec_err;
            if (bus_req && !bus_we)
                rd_data <= rd_next;
        end
    end

    // R4: every read is answered in the next cycle
    assert_rd_latency_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we) |=> rd_valid);

    // R4: no answer without a read
    assert_no_spurious_rd_R4: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && !bus_we) |=> !rd_valid);

    // R2: the error flag only follows a request
    assert_err_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_req |=> !acc_err);

    // R2: a rejected read returns zero
    assert_err_rd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && acc_err) |-> rd_data == 64'd0);

endmodule

// File: tb/test_dmareg_bank.sv
module test_dmareg_bank;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int AW = 16;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic            rst;
    logic            bus_req, bus_we;
    logic [AW-1:0]   bus_addr;
    logic [3:0]      bus_size;
    logic [63:0]     bus_wdata;
    logic            rd_valid, acc_err;
    logic [63:0]     rd_data;
    logic [N-1:0]    cmd_start, cmd_append, cmd_reset;
    logic [N-1:0]    seq_busy, seq_cmpl_upd;
    logic [N*64-1:0] seq_cmpl_word;
    logic [N*32-1:0] seq_err_set;

    dmareg_bank #(.N_CHAN(N), .AW(AW)) i_dmareg_bank (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err),
        .cmd_start(cmd_start), .cmd_append(cmd_append), .cmd_reset(cmd_reset),
        .seq_busy(seq_busy), .seq_cmpl_upd(seq_cmpl_upd),
        .seq_cmpl_word(seq_cmpl_word), .seq_err_set(seq_err_set)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [15:0] m_ctrl   [N];
    logic [63:0] m_status [N];
    logic [63:0] m_chain  [N];
    logic [63:0] m_cmpl   [N];
    logic [7:0]  m_cmd    [N];
    logic [31:0] m_err    [N];

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic bit unsup(input logic [7:0] d);
        return (d[2] | d[3] | d[5]) && !(d[0] | d[1] | d[4]);
    endfunction

    function automatic bit exp_err(input bit we, input logic [AW-1:0] a,
                                   input logic [3:0] s, input logic [63:0] d);
        int win;
        int off;
        win = int'(a >> 7);
        off = int'(a[6:0]);
        if (!(s == 1 || s == 2 || s == 4 || s == 8)) return 1;
        if (win == 0) return !(off == 0 && s == 1);
        if (win > N) return 1;
        case (off)
            'h00: return s != 2;
            'h08: return s != 8;
            'h10, 'h20: return !(s == 8 || s == 4);
            'h14, 'h24, 'h28: return s != 4;
            'h18: return (s != 1) || (we && unsup(d[7:0]));
            default: return 1;
        endcase
    endfunction

    function automatic logic [63:0] exp_read(input int ch, input int off, input logic [3:0] s);
        case (off)
            'h00: return {48'd0, m_ctrl[ch]};
            'h08: return m_status[ch] | {63'd0, ~seq_busy[ch]};
            'h10: return (s == 8) ? m_chain[ch] : {32'd0, m_chain[ch][31:0]};
            'h14: return {32'd0, m_chain[ch][63:32]};
            'h18: return {56'd0, m_cmd[ch]};
            'h20: return (s == 8) ? m_cmpl[ch] : {32'd0, m_cmpl[ch][31:0]};
            'h24: return {32'd0, m_cmpl[ch][63:32]};
            'h28: return {32'd0, m_err[ch]};
            default: return 64'd0;
        endcase
    endfunction

    task automatic step(input string tag, input bit we, input logic [AW-1:0] a,
                        input logic [3:0] s, input logic [63:0] d);
        bit          e;
        logic [63:0] er;
        logic [N-1:0] es, ea, ers;
        int win, off, ch;
        e   = exp_err(we, a, s, d);
        win = int'(a >> 7);
        off = int'(a[6:0]);
        ch  = win - 1;
        er  = 64'd0;
        es  = '0; ea = '0; ers = '0;
        if (!e && !we) er = (win == 0) ? 64'(N) : exp_read(ch, off, s);
        if (!e && we && win != 0) begin
            case (off)
                'h00: m_ctrl[ch] = {d[15:1], d[0] ? 1'b0 : m_ctrl[ch][0]};
                'h10: if (s == 8) m_chain[ch] = d; else m_chain[ch][31:0] = d[31:0];
                'h14: m_chain[ch][63:32] = d[31:0];
                'h20: if (s == 8) m_cmpl[ch] = d; else m_cmpl[ch][31:0] = d[31:0];
                'h24: m_cmpl[ch][63:32] = d[31:0];
                'h28: m_err[ch] = m_err[ch] & ~d[31:0];
                'h18: begin
                    m_cmd[ch] = d[7:0];
                    if (d[0]) begin es[ch] = 1'b1; m_status[ch][2:0] = 3'd0; end
                    else if (d[1]) ea[ch] = 1'b1;
                    else if (d[4]) begin ers[ch] = 1'b1; m_status[ch][2:0] = 3'd3; end
                end
                default: ;
            endcase
        end
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = s; bus_wdata = d;
        @(posedge clk);
        #1;
        chk({tag, " rd_valid"}, 64'(rd_valid), 64'(!we));
        chk({tag, " acc_err"}, 64'(acc_err), 64'(e));
        if (!we) chk({tag, " rd_data"}, rd_data, er);
        chk({tag, " pulses"}, 64'({cmd_start, cmd_append, cmd_reset}), 64'({es, ea, ers}));
        bus_req = 1'b0;
    endtask

    task automatic seq_event(input int ch, input bit upd, input logic [63:0] w,
                             input logic [31:0] set);
        @(negedge clk);
        seq_cmpl_upd[ch] = upd;
        seq_cmpl_word[ch*64 +: 64] = w;
        seq_err_set[ch*32 +: 32] = set;
        if (upd) m_status[ch] = w;
        m_err[ch] = m_err[ch] | set;
        @(posedge clk);
        #1;
        seq_cmpl_upd = '0;
        seq_err_set  = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    int offs [10] = '{'h00, 'h08, 'h10, 'h14, 'h18, 'h20, 'h24, 'h28, 'h30, 'h0C};
    int szs  [5]  = '{1, 2, 4, 8, 3};

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; bus_req = 0; bus_we = 0; bus_addr = '0; bus_size = '0; bus_wdata = '0;
        seq_busy = '0; seq_cmpl_upd = '0; seq_cmpl_word = '0; seq_err_set = '0;
        for (int i = 0; i < N; i++) begin
            m_ctrl[i] = 16'h0001; m_status[i] = 64'd3; m_chain[i] = '0;
            m_cmpl[i] = '0; m_cmd[i] = '0; m_err[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R12 idle outputs", 64'({rd_valid, acc_err, cmd_start, cmd_append, cmd_reset}), 64'd0);

        // R12 reset values
        step("R12 ctrl",   0, 16'h0080, 2, 0);
        step("R12 status", 0, 16'h0088, 8, 0);
        step("R12 chain",  0, 16'h0090, 8, 0);
        step("R12 cmd",    0, 16'h0098, 1, 0);
        step("R12 cmpl",   0, 16'h01A0, 8, 0);
        step("R12 err",    0, 16'h01A8, 4, 0);

        // R1 decode
        step("R1 channel count", 0, 16'h0000, 1, 0);
        step("R1 count write ignored", 1, 16'h0000, 1, 64'hFF);
        step("R1 count reread", 0, 16'h0000, 1, 0);
        step("R1 last channel", 0, 16'h0200, 2, 0);

        // R2, R3 rejection
        step("R2 channel out of range", 0, 16'h0280, 2, 0);
        step("R2 unknown offset", 0, 16'h0130, 8, 0);
        step("R2 wrong size", 0, 16'h0080, 4, 0);
        step("R2 rejected write", 1, 16'h0090, 2, 64'hDEAD);
        step("R2 no side effect", 0, 16'h0090, 8, 0);
        step("R3 size 3", 0, 16'h0088, 3, 0);
        step("R3 size 0", 1, 16'h0098, 0, 64'h01);
        step("R3 size 15", 0, 16'h0088, 15, 0);

        // R4 latency
        step("R4 write no valid", 1, 16'h0080, 2, 64'h0100);
        step("R4 read latency", 0, 16'h0080, 2, 0);

        // R6 pointer halves
        step("R6 full write", 1, 16'h0090, 8, 64'h1122334455667788);
        step("R6 low write", 1, 16'h0090, 4, 64'hFFFFFFFFAABBCCDD);
        step("R6 full read", 0, 16'h0090, 8, 0);
        step("R6 high write", 1, 16'h0094, 4, 64'h0000000099887766);
        step("R6 high read", 0, 16'h0094, 4, 0);
        step("R6 low read", 0, 16'h0090, 4, 0);
        step("R6 cmpl full", 1, 16'h00A0, 8, 64'hCAFEF00D12345678);
        step("R6 cmpl high", 1, 16'h00A4, 4, 64'h0BADBEEF);
        step("R6 cmpl read", 0, 16'h00A0, 8, 0);

        // R9 commands and R5 status
        step("R9 start", 1, 16'h0098, 1, 64'h01);
        step("R5 idle bit", 0, 16'h0088, 8, 0);
        seq_busy[0] = 1'b1;
        step("R5 busy status", 0, 16'h0088, 8, 0);
        step("R5 status write ignored", 1, 16'h0088, 8, 64'hFFFFFFFFFFFFFFFF);
        step("R5 status unchanged", 0, 16'h0088, 8, 0);
        seq_busy[0] = 1'b0;
        step("R9 append beats reset", 1, 16'h0098, 1, 64'h12);
        step("R9 start beats all", 1, 16'h0098, 1, 64'h13);
        step("R9 reset", 1, 16'h0098, 1, 64'h10);
        step("R9 status after reset", 0, 16'h0088, 8, 0);
        step("R9 cmd readback", 0, 16'h0098, 1, 0);

        // R10 unsupported
        step("R10 suspend", 1, 16'h0098, 1, 64'h04);
        step("R10 abort", 1, 16'h0098, 1, 64'h08);
        step("R10 resume", 1, 16'h0098, 1, 64'h20);
        step("R10 cmd kept", 0, 16'h0098, 1, 0);
        step("R10 mixed with start", 1, 16'h0098, 1, 64'h09);

        // R7 error register
        seq_event(1, 0, 0, 32'hF0F0);
        step("R7 set visible", 0, 16'h0128, 4, 0);
        step("R7 clear ones", 1, 16'h0128, 4, 64'h30);
        step("R7 zero write", 1, 16'h0128, 4, 64'h0);
        step("R7 after clear", 0, 16'h0128, 4, 0);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = 16'h0128; bus_size = 4; bus_wdata = 64'hFFFFFFFF;
        seq_err_set[32 +: 32] = 32'h0000_0100;
        m_err[1] = 32'h0000_0100;
        @(posedge clk);
        #1;
        bus_req = 0; seq_err_set = '0;
        step("R7 set wins over clear", 0, 16'h0128, 4, 0);

        // R8 interrupt disable
        step("R8 write zero keeps", 1, 16'h0100, 2, 64'h0000);
        step("R8 keep read", 0, 16'h0100, 2, 0);
        step("R8 write one clears", 1, 16'h0100, 2, 64'h00A1);
        step("R8 clear read", 0, 16'h0100, 2, 0);

        // R11 completion load
        seq_event(2, 1, 64'h123456789ABCDEF0, 0);
        step("R11 loaded status", 0, 16'h0188, 8, 0);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = 16'h0198; bus_size = 1; bus_wdata = 64'h10;
        seq_cmpl_upd[2] = 1; seq_cmpl_word[128 +: 64] = 64'h00000000000000F4;
        m_status[2] = 64'h00000000000000F3; m_cmd[2] = 8'h10;
        @(posedge clk);
        #1;
        chk("R11 reset pulse", 64'(cmd_reset), 64'b0100);
        bus_req = 0; seq_cmpl_upd = '0;
        step("R11 command overrides field", 0, 16'h0188, 8, 0);

        // Random mix
        for (int it = 0; it < 600; it++) begin
            int ch, oi, si;
            logic [63:0] d;
            ch = $urandom_range(0, 4);
            oi = $urandom_range(0, 9);
            si = $urandom_range(0, 4);
            d  = {$urandom(), $urandom()};
            seq_busy = N'($urandom());
            if ($urandom_range(0, 7) == 0)
                seq_event($urandom_range(0, N-1), $urandom_range(0, 1),
                          {$urandom(), $urandom()}, $urandom());
            step("R6 R9 random", $urandom_range(0, 1),
                 AW'(32'h80 * (ch + 1) + offs[oi]), 4'(szs[si]), d);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule